// File: doc/BRIEF.md
# Operand Bypass Selection Unit

This block sits in the register-read stage of a four-stage pipeline (fetch, register read, ALU, write-back). For each of the two source operands it picks one of three values: the raw register-file read data, the result the ALU stage is producing in this cycle, or the data being written back in this cycle. Without it, an instruction that reads a register just written by one of the two instructions ahead of it would see a stale value. That would force a stall or a software rewrite. With it, back-to-back dependent instructions run at full rate.

The choice is made from the register-read instruction word, the ALU-stage instruction word and the write-back write port. The chosen operands are captured into the operand registers that feed the ALU stage on the next clock edge. The register file and the ALU are outside the block. The register file's second read port is assumed to be addressed by the store-data field when the instruction is a store.

Top module: `operand_bypass`

## Requirements
- R1: While `rstN` is low, `opA` and `opB` read 0.
- R2: Let the register-read instruction read its first operand, let that operand's address be bits 20:16 and not 31, and let the ALU-stage instruction have opcode bits 31:26 with bit 31 set (register or constant ALU class, 0x20 to 0x3F) and destination bits 25:21 equal to that address. Then `opA` takes `aluResult` at the next rising edge.
- R3: An ALU-stage instruction whose opcode bit 31 is clear (for example load 0x18 or relative load 0x1F) is never forwarded from the ALU stage, whatever its destination field holds.
- R4: If the operand is read, its address is not 31, the ALU path is not chosen, `wbWe` is 1 and `wbWa` equals the address, the operand takes `wbData` at the next edge.
- R5: When both the ALU path and the write-back path match, the ALU path wins.
- R6: An operand whose address is 31 is 0, whatever the read data and the later stages carry.
- R7: When no forwarding condition holds, the operand is the matching register-file read data (`rfRdA` or `rfRdB`).
- R8: The second operand follows the same rules with address bits 15:11, except for a store (opcode 0x19), whose second operand uses bits 25:21.
- R9: The first operand is read only by ALU-class, load (0x18), store (0x19), jump (0x1B) and branch (0x1C, 0x1D) opcodes. The second is read only by register-ALU opcodes (0x20 to 0x2F) and stores. For an operand that is not read, no forwarding happens and the register-file data passes through.
- R10: An add writing r3 followed directly by a compare reading r3 gives the compare the new r3 value in the very next cycle, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rrInstr | input | 32 | Instruction in the register-read stage |
| aluInstr | input | 32 | Instruction in the ALU stage |
| aluResult | input | DATA_W | ALU output this cycle |
| wbWa | input | 5 | Write-back register address |
| wbWe | input | 1 | Write-back write enable |
| wbData | input | DATA_W | Write-back data |
| rfRdA | input | DATA_W | Register-file first read port data |
| rfRdB | input | DATA_W | Register-file second read port data |
| opA | output | DATA_W | Forwarded first operand, registered for the ALU stage |
| opB | output | DATA_W | Forwarded second operand, registered for the ALU stage |

## Verification
A wrong select strobe shows up one edge later as an operand equal to the wrong one of the three sources, or as a nonzero value for register 31. The bench drives the three sources with values that differ from each other in every directed case, so any misselection differs from the expected operand in that same cycle. A fault in the store address redirect or in the opcode class decode changes only the second operand, or only the case of a load in the ALU stage, so directed cases aim at each of these.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  localparam int INSTR_W  = 32;
  localparam int REG_W    = 5;
  localparam int OP_W     = 6;
  localparam int OP_LSB   = INSTR_W - OP_W;
  localparam int RC_LSB   = OP_LSB - REG_W;
  localparam int RA_LSB   = RC_LSB - REG_W;
  localparam int RB_LSB   = RA_LSB - REG_W;
  localparam int NUM_SRC  = 2;

  typedef logic [OP_W-1:0]    opcode_t;
  typedef logic [REG_W-1:0]   regIdx_t;
  typedef logic [INSTR_W-1:0] instr_t;

  localparam regIdx_t ZERO_REG = '1;

  localparam opcode_t OPC_LD  = 6'h18;
  localparam opcode_t OPC_ST  = 6'h19;
  localparam opcode_t OPC_JMP = 6'h1B;
  localparam opcode_t OPC_BEQ = 6'h1C;
  localparam opcode_t OPC_BNE = 6'h1D;

  typedef struct packed {
    logic fromAlu;
    logic fromWb;
    logic forceZero;
  } opSel_t;

  typedef struct packed {
    opSel_t a;
    opSel_t b;
  } bypassSel_t;

  function automatic opcode_t opcodeOf(instr_t i);
    return i[OP_LSB +: OP_W];
  endfunction

  function automatic regIdx_t rcOf(instr_t i);
    return i[RC_LSB +: REG_W];
  endfunction

  function automatic regIdx_t raOf(instr_t i);
    return i[RA_LSB +: REG_W];
  endfunction

  function automatic regIdx_t rbOf(instr_t i);
    return i[RB_LSB +: REG_W];
  endfunction

  function automatic logic isAluClass(opcode_t op);
    return op[OP_W-1];
  endfunction

  function automatic logic isRegAlu(opcode_t op);
    return op[OP_W-1 -: 2] == 2'b10;
  endfunction

  function automatic logic readsFirst(opcode_t op);
    return isAluClass(op) || op == OPC_LD || op == OPC_ST ||
           op == OPC_JMP || op == OPC_BEQ || op == OPC_BNE;
  endfunction

  function automatic logic readsSecond(opcode_t op);
    return isRegAlu(op) || op == OPC_ST;
  endfunction

  function automatic regIdx_t secondAddr(instr_t i);
    return (opcodeOf(i) == OPC_ST) ? rcOf(i) : rbOf(i);
  endfunction
endpackage

// File: rtl/bypass_ctrl.sv
module bypass_ctrl
  import bypass_pkg::*;
(
  input  instr_t     rrInstr,
  input  instr_t     aluInstr,
  input  regIdx_t    wbWa,
  input  logic       wbWe,
  output bypassSel_t sel
);
  opcode_t rrOp;
  opcode_t aluOp;
  regIdx_t aluDest;
  logic    aluProduces;

  regIdx_t srcAddr [NUM_SRC];
  logic    srcRead [NUM_SRC];
  opSel_t  srcSel  [NUM_SRC];

  assign rrOp        = opcodeOf(rrInstr);
  assign aluOp       = opcodeOf(aluInstr);
  assign aluDest     = rcOf(aluInstr);
  assign aluProduces = isAluClass(aluOp);

  assign srcAddr[0] = raOf(rrInstr);
  assign srcRead[0] = readsFirst(rrOp);
  assign srcAddr[1] = secondAddr(rrInstr);
  assign srcRead[1] = readsSecond(rrOp);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic isZero;
    logic aluHit;
    logic wbHit;
    assign isZero = srcAddr[g] == ZERO_REG;
    assign aluHit = srcRead[g] && !isZero && aluProduces && (aluDest == srcAddr[g]);
    assign wbHit  = srcRead[g] && !isZero && wbWe && (wbWa == srcAddr[g]);
    always_comb begin
      srcSel[g].forceZero = isZero;
      srcSel[g].fromAlu   = aluHit;
      srcSel[g].fromWb    = wbHit && !aluHit;
    end
  end

  assign sel.a = srcSel[0];
  assign sel.b = srcSel[1];
endmodule

// File: rtl/bypass_dpath.sv
module bypass_dpath
  import bypass_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  bypassSel_t        sel,
  input  logic [DATA_W-1:0] aluResult,
  input  logic [DATA_W-1:0] wbData,
  input  logic [DATA_W-1:0] rfRdA,
  input  logic [DATA_W-1:0] rfRdB,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB
);
  logic [DATA_W-1:0] rfData  [NUM_SRC];
  logic [DATA_W-1:0] nextOp  [NUM_SRC];
  logic [DATA_W-1:0] opReg   [NUM_SRC];
  opSel_t            srcSel  [NUM_SRC];

  assign rfData[0] = rfRdA;
  assign rfData[1] = rfRdB;
  assign srcSel[0] = sel.a;
  assign srcSel[1] = sel.b;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_mux
    always_comb begin
      if (srcSel[g].forceZero)    nextOp[g] = '0;
      else if (srcSel[g].fromAlu) nextOp[g] = aluResult;
      else if (srcSel[g].fromWb)  nextOp[g] = wbData;
      else                        nextOp[g] = rfData[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) opReg[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) opReg[i] <= nextOp[i];
    end
  end

  assign opA = opReg[0];
  assign opB = opReg[1];
endmodule

// File: rtl/operand_bypass.sv
module operand_bypass
  import bypass_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       rrInstr,
  input  logic [31:0]       aluInstr,
  input  logic [DATA_W-1:0] aluResult,
  input  logic [4:0]        wbWa,
  input  logic              wbWe,
  input  logic [DATA_W-1:0] wbData,
  input  logic [DATA_W-1:0] rfRdA,
  input  logic [DATA_W-1:0] rfRdB,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB
);
  bypassSel_t sel;

  bypass_ctrl u_ctrl (
    .rrInstr (rrInstr),
    .aluInstr(aluInstr),
    .wbWa    (wbWa),
    .wbWe    (wbWe),
    .sel     (sel)
  );

  bypass_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .sel      (sel),
    .aluResult(aluResult),
    .wbData   (wbData),
    .rfRdA    (rfRdA),
    .rfRdB    (rfRdB),
    .opA      (opA),
    .opB      (opB)
  );
endmodule

// File: rtl/bypass_checker.sv
module bypass_checker
  import bypass_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [31:0]       rrInstr,
  input logic [31:0]       aluInstr,
  input logic [DATA_W-1:0] aluResult,
  input logic [4:0]        wbWa,
  input logic              wbWe,
  input logic [DATA_W-1:0] wbData,
  input logic [DATA_W-1:0] rfRdA,
  input logic [DATA_W-1:0] rfRdB,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB
);
  logic aluMatchA;
  logic aluMatchStore;
  assign aluMatchA = readsFirst(opcodeOf(rrInstr)) && raOf(rrInstr) != ZERO_REG &&
                     isAluClass(opcodeOf(aluInstr)) && rcOf(aluInstr) == raOf(rrInstr);
  assign aluMatchStore = opcodeOf(rrInstr) == OPC_ST && rcOf(rrInstr) != ZERO_REG &&
                         isAluClass(opcodeOf(aluInstr)) && rcOf(aluInstr) == rcOf(rrInstr);

  p_alu_fwd_r2: assert property (@(posedge clk) disable iff (!rstN)
    aluMatchA |=> opA == $past(aluResult));

  p_wb_fwd_r4: assert property (@(posedge clk) disable iff (!rstN)
    (readsFirst(opcodeOf(rrInstr)) && raOf(rrInstr) != ZERO_REG && !aluMatchA &&
     wbWe && wbWa == raOf(rrInstr)) |=> opA == $past(wbData));

  p_zero_a_r6: assert property (@(posedge clk) disable iff (!rstN)
    raOf(rrInstr) == ZERO_REG |=> opA == '0);

  p_zero_b_r6: assert property (@(posedge clk) disable iff (!rstN)
    secondAddr(rrInstr) == ZERO_REG |=> opB == '0);

  p_store_b_r8: assert property (@(posedge clk) disable iff (!rstN)
    aluMatchStore |=> opB == $past(aluResult));

  p_noread_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!readsFirst(opcodeOf(rrInstr)) && raOf(rrInstr) != ZERO_REG) |=> opA == $past(rfRdA));
endmodule

bind operand_bypass bypass_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .rrInstr(rrInstr), .aluInstr(aluInstr),
  .aluResult(aluResult), .wbWa(wbWa), .wbWe(wbWe), .wbData(wbData),
  .rfRdA(rfRdA), .rfRdB(rfRdB), .opA(opA), .opB(opB)
);

// File: tb/operand_bypass_test.sv
module operand_bypass_test;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [31:0]   rrInstr = '0;
  logic [31:0]   aluInstr = '0;
  logic [DW-1:0] aluResult = '0;
  logic [4:0]    wbWa = '0;
  logic          wbWe = 1'b0;
  logic [DW-1:0] wbData = '0;
  logic [DW-1:0] rfRdA = '0;
  logic [DW-1:0] rfRdB = '0;
  logic [DW-1:0] opA;
  logic [DW-1:0] opB;

  int  nRun = 0;
  int  nFail = 0;
  bit  done = 0;
  logic [DW-1:0] expQ [$];

  always #4 clk = ~clk;

  operand_bypass #(.DATA_W(DW)) uut (.*);

  function automatic logic [31:0] mk(int op, int rc, int ra, int rb);
    logic [31:0] w;
    w = '0;
    w[31:26] = 6'(op);
    w[25:21] = 5'(rc);
    w[20:16] = 5'(ra);
    w[15:11] = 5'(rb);
    return w;
  endfunction

  // behavioural reference: one operand's value for the applied inputs
  function automatic logic [DW-1:0] model(bit second);
    int op, addr, aop, adst;
    bit reads;
    op   = int'(rrInstr[31:26]);
    aop  = int'(aluInstr[31:26]);
    adst = int'(aluInstr[25:21]);
    if (!second) begin
      addr  = int'(rrInstr[20:16]);
      reads = (op >= 32) || op == 24 || op == 25 || op == 27 || op == 28 || op == 29;
    end else begin
      addr  = (op == 25) ? int'(rrInstr[25:21]) : int'(rrInstr[15:11]);
      reads = (op >= 32 && op < 48) || op == 25;
    end
    if (addr == 31) return '0;
    if (reads && aop >= 32 && adst == addr) return aluResult;
    if (reads && wbWe && int'(wbWa) == addr) return wbData;
    return second ? rfRdB : rfRdA;
  endfunction

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // apply at negedge, capture at posedge, compare at following negedge
  task automatic step(string tag);
    logic [DW-1:0] eA, eB;
    expQ.push_back(model(1'b0));
    expQ.push_back(model(1'b1));
    @(posedge clk);
    @(negedge clk);
    eA = expQ.pop_front();
    eB = expQ.pop_front();
    check(tag, "opA", opA, eA);
    check(tag, "opB", opB, eB);
  endtask

  task automatic setSrc(logic [DW-1:0] ar, logic [4:0] wa, logic we, logic [DW-1:0] wd,
                        logic [DW-1:0] ra, logic [DW-1:0] rb);
    aluResult = ar; wbWa = wa; wbWe = we; wbData = wd; rfRdA = ra; rfRdB = rb;
  endtask

  int pickOps[8] = '{32, 48, 54, 24, 25, 31, 28, 27};

  function automatic int pickReg();
    if ($urandom % 5 == 0) return 31;
    return int'($urandom % 3) + 1;
  endfunction

  initial begin
    // R1: reset holds operands at zero
    rrInstr = mk(32, 3, 1, 2);
    setSrc(32'hAAAA_0001, 5'd1, 1'b1, 32'hBBBB_0002, 32'hCCCC_0003, 32'hDDDD_0004);
    repeat (3) @(negedge clk);
    check("R1", "opA", opA, '0);
    check("R1", "opB", opB, '0);
    rstN = 1'b1;

    // R7: no hazard, register-file data passes
    rrInstr = mk(32, 3, 1, 2); aluInstr = mk(32, 7, 4, 5);
    setSrc(32'h11, 5'd6, 1'b1, 32'h22, 32'h33, 32'h44);
    step("R7");

    // R10 / R2: ADD r1,r2,r3 then CMPLEC r3,100,r0 with no stall
    aluInstr = mk(32, 3, 1, 2); rrInstr = mk(54, 0, 3, 0) | 32'd100;
    setSrc(32'd77, 5'd9, 1'b1, 32'h55, 32'h66, 32'h64);
    step("R10");

    // R4: write-back path
    aluInstr = mk(32, 7, 1, 2); rrInstr = mk(32, 4, 5, 6);
    setSrc(32'h1001, 5'd5, 1'b1, 32'h2002, 32'h3003, 32'h4004);
    step("R4");
    setSrc(32'h1001, 5'd6, 1'b1, 32'h2002, 32'h3003, 32'h4004);
    step("R4");
    setSrc(32'h1001, 5'd5, 1'b0, 32'h2002, 32'h3003, 32'h4004);
    step("R4");

    // R5: both paths match, ALU wins
    aluInstr = mk(48, 5, 1, 0); rrInstr = mk(32, 4, 5, 5);
    setSrc(32'h5A5A, 5'd5, 1'b1, 32'hA5A5, 32'h1111, 32'h2222);
    step("R5");

    // R3: load in ALU stage is never forwarded from there
    aluInstr = mk(24, 5, 1, 0); rrInstr = mk(32, 4, 5, 5);
    setSrc(32'h5A5A, 5'd5, 1'b1, 32'hA5A5, 32'h1111, 32'h2222);
    step("R3");
    aluInstr = mk(31, 5, 0, 0);
    setSrc(32'h5A5A, 5'd5, 1'b0, 32'hA5A5, 32'h1111, 32'h2222);
    step("R3");

    // R6: register 31 reads zero even if later stages name it
    aluInstr = mk(32, 31, 1, 2); rrInstr = mk(32, 4, 31, 31);
    setSrc(32'h7777, 5'd31, 1'b1, 32'h8888, 32'h9999, 32'hAAAA);
    step("R6");

    // R8: store second operand uses bits 25:21
    aluInstr = mk(32, 5, 1, 2); rrInstr = mk(25, 5, 2, 6);
    setSrc(32'hCAFE, 5'd6, 1'b1, 32'hBEEF, 32'h0123, 32'h4567);
    step("R8");
    // R8: register ALU op uses bits 15:11 for the second operand
    aluInstr = mk(32, 9, 1, 2); rrInstr = mk(32, 5, 2, 6);
    step("R8");

    // R9: constant op does not read its second field; relative load reads neither
    aluInstr = mk(32, 6, 1, 2); rrInstr = mk(48, 1, 2, 6);
    setSrc(32'hF00D, 5'd2, 1'b1, 32'hD00F, 32'h0AAA, 32'h0BBB);
    step("R9");
    aluInstr = mk(32, 2, 1, 2); rrInstr = mk(31, 1, 2, 2);
    step("R9");

    // R2: several register pairings through random traffic
    for (int i = 0; i < 60; i++) begin
      rrInstr  = mk(pickOps[$urandom % 8], pickReg(), pickReg(), pickReg());
      aluInstr = mk(pickOps[$urandom % 8], pickReg(), pickReg(), pickReg());
      setSrc($urandom, 5'(pickReg()), 1'($urandom), $urandom, $urandom, $urandom);
      step("R2");
    end

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nRun++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule